// File: doc/BRIEF.md
# Dual-Mode Timer with Interrupt Registers

This block is a register-mapped timer. It has two run modes, picked by a configuration register. In down-count mode, a full-width counter is loaded from two half-width load registers and counts down on every clock. A timeout can stop the timer (one-shot) or reload it (periodic), and it can also drive a one-clock trigger pulse for a converter. In seconds mode, a counter steps once per `sec_tick` strobe. It wraps to zero after passing a programmable match value.

Each mode has its own bit in a raw status register. The mask register, the masked view and the write-one-to-clear register together produce a level interrupt. The register port is a plain word-addressed bus with no back-pressure. A write completes in the cycle `bus_wen` is high, and `bus_rdata` follows `bus_addr` within the same cycle. The block carries no data stream, so it has no valid/ready pair.

Top module: `dual_timer`

Word map: 0 config, 1 mode A, 2 mode B, 3 control, 4 mask, 5 raw status, 6 masked status, 7 clear, 8 combined load, 9 upper load half, 10 combined match, 11 upper match half, 12 seconds value, 13 and 14 scratch prescale words, 15 unused.

## Requirements
- R1: After reset, every address reads 0, and both `irq` and `trig` are low.
- R2: The reload value is {upper load half, lower load half}. A write to address 8 stores bits 15:0 in the lower half, and stores bits 31:16 in the upper half only while config is below 4. A read of address 8 returns the combined value under the same condition and the lower half alone otherwise. Address 9 reads and writes the upper half through bits 15:0. Match addresses 10 and 11 behave the same way.
- R3: With config 0, a write that takes control bit 0 from 0 to 1 loads the counter with the reload value. The timeout then occurs on the clock edge reload+1 cycles after the write edge, and it sets raw status bit 0.
- R4: With mode A bit 0 clear, the timer reloads at each timeout and times out again every reload+1 cycles.
- R5: With mode A bit 0 set, a timeout clears control bit 0. A control write in the same cycle takes precedence over this clear.
- R6: When control bit 5 is set at a timeout, `trig` is high for exactly the cycle after the timeout edge.
- R7: With config 1 and control bit 0 set, each cycle with `sec_tick` high advances the seconds counter. If the counter is already at or above the match value, it goes to 0 instead and sets raw status bit 3. Address 12 reads the counter. With control bit 0 clear, ticks have no effect.
- R8: The mask register keeps only bits 0x77 of a write. Address 6 reads raw AND mask, and `irq` is high exactly when that value is nonzero.
- R9: A write to address 7 clears every raw bit written as 1, and address 7 reads 0. A status bit set by an event in the same cycle stays set.
- R10: Address 15 reads 0, and writes to it change no register.
- R11: A write that takes control bit 0 from 1 to 0 stops the down-counter, and no further timeouts occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_wen | input | 1 | Write strobe |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| sec_tick | input | 1 | Once-per-second advance strobe |
| irq | output | 1 | Level interrupt, masked status nonzero |
| trig | output | 1 | One-cycle pulse after a timeout when enabled |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a down-count timeout setting raw bit 0 and a software clear of that bit. The second is a one-shot timeout clearing the enable and a software write to the control register. The bench counts cycles from the enabling write so that the clear write, and separately the control write, lands on the exact timeout edge. It then reads raw status and control back and expects the event bit to survive and the written control value to stand. A behavioural model updated on every edge also judges `irq` and `trig` in every cycle around these collisions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // word offsets
  localparam int unsigned OFS_CFG   = 0;
  localparam int unsigned OFS_MODEA = 1;
  localparam int unsigned OFS_MODEB = 2;
  localparam int unsigned OFS_CTL   = 3;
  localparam int unsigned OFS_MASK  = 4;
  localparam int unsigned OFS_RAW   = 5;
  localparam int unsigned OFS_MSKD  = 6;
  localparam int unsigned OFS_CLR   = 7;
  localparam int unsigned OFS_LOADA = 8;
  localparam int unsigned OFS_LOADB = 9;
  localparam int unsigned OFS_MATA  = 10;
  localparam int unsigned OFS_MATB  = 11;
  localparam int unsigned OFS_VAL   = 12;
  localparam int unsigned OFS_PREA  = 13;
  localparam int unsigned OFS_PREB  = 14;
  // control and status bit positions
  localparam int unsigned CTL_RUN   = 0;
  localparam int unsigned CTL_TRIG  = 5;
  localparam int unsigned ST_TMO    = 0;
  localparam int unsigned ST_WRAP   = 3;
  // config values
  localparam int unsigned CFG_SECS  = 1;
  localparam int unsigned CFG_SPLIT = 4;
  localparam logic [31:0] MASK_KEEP = 32'h0000_0077;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wen,
  output logic [DW-1:0] bus_rdata,
  input  logic          tmo,
  input  logic          wrap,
  input  logic [DW-1:0] secs_val,
  output logic          run_en,
  output logic          trig_en,
  output logic          oneshot,
  output logic          down_sel,
  output logic          secs_sel,
  output logic          start,
  output logic [DW-1:0] reload,
  output logic [DW-1:0] match_val,
  output logic [DW-1:0] mask_q,
  output logic          st_tmo,
  output logic          st_wrap,
  output logic          irq
);
  localparam int HW = DW / 2;

  logic [DW-1:0] cfg, mode_a, mode_b, ctl, raw, pre_a, pre_b;
  logic [HW-1:0] load_lo, load_hi, mat_lo, mat_hi;
  logic [DW-1:0] clr_bits, set_bits;
  logic          split;

  function automatic logic hit(input logic [AW-1:0] a, input int unsigned ofs);
    return a == AW'(ofs);
  endfunction

  assign split    = cfg >= DW'(CFG_SPLIT);
  assign clr_bits = (bus_wen && hit(bus_addr, OFS_CLR)) ? bus_wdata : '0;
  assign set_bits = (DW'(tmo) << ST_TMO) | (DW'(wrap) << ST_WRAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0; mode_a <= '0; mode_b <= '0; ctl <= '0; mask_q <= '0;
      raw <= '0; pre_a <= '0; pre_b <= '0;
      load_lo <= '0; load_hi <= '0; mat_lo <= '0; mat_hi <= '0;
    end else begin
      raw <= (raw & ~clr_bits) | set_bits;
      if (bus_wen && hit(bus_addr, OFS_CTL)) ctl <= bus_wdata;
      else if (tmo && mode_a[0])             ctl[CTL_RUN] <= 1'b0;
      if (bus_wen) begin
        if (hit(bus_addr, OFS_CFG))   cfg    <= bus_wdata;
        if (hit(bus_addr, OFS_MODEA)) mode_a <= bus_wdata;
        if (hit(bus_addr, OFS_MODEB)) mode_b <= bus_wdata;
        if (hit(bus_addr, OFS_MASK))  mask_q <= bus_wdata & DW'(MASK_KEEP);
        if (hit(bus_addr, OFS_PREA))  pre_a  <= bus_wdata;
        if (hit(bus_addr, OFS_PREB))  pre_b  <= bus_wdata;
        if (hit(bus_addr, OFS_LOADA)) begin
          load_lo <= bus_wdata[HW-1:0];
          if (!split) load_hi <= bus_wdata[DW-1:HW];
        end
        if (hit(bus_addr, OFS_LOADB)) load_hi <= bus_wdata[HW-1:0];
        if (hit(bus_addr, OFS_MATA)) begin
          mat_lo <= bus_wdata[HW-1:0];
          if (!split) mat_hi <= bus_wdata[DW-1:HW];
        end
        if (hit(bus_addr, OFS_MATB)) mat_hi <= bus_wdata[HW-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      AW'(OFS_CFG):   bus_rdata = cfg;
      AW'(OFS_MODEA): bus_rdata = mode_a;
      AW'(OFS_MODEB): bus_rdata = mode_b;
      AW'(OFS_CTL):   bus_rdata = ctl;
      AW'(OFS_MASK):  bus_rdata = mask_q;
      AW'(OFS_RAW):   bus_rdata = raw;
      AW'(OFS_MSKD):  bus_rdata = raw & mask_q;
      AW'(OFS_LOADA): bus_rdata = {split ? {HW{1'b0}} : load_hi, load_lo};
      AW'(OFS_LOADB): bus_rdata = {{HW{1'b0}}, load_hi};
      AW'(OFS_MATA):  bus_rdata = {split ? {HW{1'b0}} : mat_hi, mat_lo};
      AW'(OFS_MATB):  bus_rdata = {{HW{1'b0}}, mat_hi};
      AW'(OFS_VAL):   bus_rdata = secs_val;
      AW'(OFS_PREA):  bus_rdata = pre_a;
      AW'(OFS_PREB):  bus_rdata = pre_b;
      default:        bus_rdata = '0;
    endcase
  end

  assign start     = bus_wen && hit(bus_addr, OFS_CTL) && bus_wdata[CTL_RUN] && !ctl[CTL_RUN];
  assign run_en    = ctl[CTL_RUN];
  assign trig_en   = ctl[CTL_TRIG];
  assign oneshot   = mode_a[0];
  assign down_sel  = (cfg == '0);
  assign secs_sel  = (cfg == DW'(CFG_SECS));
  assign reload    = {load_hi, load_lo};
  assign match_val = {mat_hi, mat_lo};
  assign st_tmo    = raw[ST_TMO];
  assign st_wrap   = raw[ST_WRAP];
  assign irq       = |(raw & mask_q);
endmodule

// File: rtl/tmr_down.sv
module tmr_down #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start,
  input  logic [DW-1:0] reload,
  output logic          tmo
);
  logic [DW-1:0] cnt;

  assign tmo = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= reload;
    else if (run)   cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end
endmodule

// File: rtl/tmr_secs.sv
module tmr_secs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [DW-1:0] match_val,
  output logic [DW-1:0] secs_val,
  output logic          wrap
);
  assign wrap = run && tick && (secs_val >= match_val);

  always_ff @(posedge clk) begin
    if (!rst_n)            secs_val <= '0;
    else if (run && tick)  secs_val <= wrap ? '0 : secs_val + 1'b1;
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wen,
  output logic [DW-1:0] bus_rdata,
  input  logic          sec_tick,
  output logic          irq,
  output logic          trig
);
  logic          run_en, trig_en, oneshot, down_sel, secs_sel, start;
  logic          tmo, wrap, st_tmo, st_wrap;
  logic [DW-1:0] reload, match_val, mask_q, secs_val;

  tmr_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wen(bus_wen),
    .bus_rdata(bus_rdata),
    .tmo(tmo), .wrap(wrap), .secs_val(secs_val),
    .run_en(run_en), .trig_en(trig_en), .oneshot(oneshot),
    .down_sel(down_sel), .secs_sel(secs_sel), .start(start),
    .reload(reload), .match_val(match_val), .mask_q(mask_q),
    .st_tmo(st_tmo), .st_wrap(st_wrap), .irq(irq)
  );

  tmr_down #(.DW(DW)) u_down (
    .clk(clk), .rst_n(rst_n), .run(run_en && down_sel), .start(start),
    .reload(reload), .tmo(tmo)
  );

  tmr_secs #(.DW(DW)) u_secs (
    .clk(clk), .rst_n(rst_n), .run(run_en && secs_sel), .tick(sec_tick),
    .match_val(match_val), .secs_val(secs_val), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) trig <= 1'b0;
    else        trig <= tmo && trig_en;
  end
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import tmr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wen,
  input logic          clr_b0,
  input logic          sec_tick,
  input logic          trig,
  input logic          tmo,
  input logic          run_en,
  input logic          trig_en,
  input logic          oneshot,
  input logic          secs_sel,
  input logic          st_tmo,
  input logic          st_wrap,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] secs_val,
  input logic [DW-1:0] match_val
);
  // R8
  mask_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~DW'(MASK_KEEP)) == '0);

  // R3
  timeout_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> st_tmo);

  // R6
  trig_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> ($past(tmo) && $past(trig_en)));

  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && oneshot && !(bus_wen && bus_addr == AW'(OFS_CTL))) |=> !run_en);

  // R7
  secs_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && run_en && secs_sel && secs_val >= match_val) |=> (secs_val == '0 && st_wrap));

  // R9
  clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == AW'(OFS_CLR) && clr_b0 && !tmo) |=> !st_tmo);
endmodule

bind dual_timer dual_timer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
  .clr_b0(bus_wdata[0]), .sec_tick(sec_tick), .trig(trig), .tmo(tmo),
  .run_en(run_en), .trig_en(trig_en), .oneshot(oneshot), .secs_sel(secs_sel),
  .st_tmo(st_tmo), .st_wrap(st_wrap), .mask_q(mask_q), .secs_val(secs_val),
  .match_val(match_val)
);

// File: tb/sim_dual_timer.sv
module sim_dual_timer;
  localparam int PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wen = 1'b0;
  logic        tick = 1'b0;
  wire  [31:0] rdata;
  wire         irq, trig;

  always #(PERIOD/2) clk = ~clk;

  dual_timer #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wen(wen), .bus_rdata(rdata), .sec_tick(tick), .irq(irq), .trig(trig)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference
  logic [31:0] m_cfg, m_ma, m_mb, m_ctl, m_mask, m_raw, m_pa, m_pb, m_cnt, m_secs;
  logic [15:0] m_llo, m_lhi, m_mlo, m_mhi;
  logic        m_trig;

  function automatic logic [31:0] m_read(input logic [3:0] a);
    logic sp = m_cfg >= 4;
    case (a)
      4'd0:  return m_cfg;
      4'd1:  return m_ma;
      4'd2:  return m_mb;
      4'd3:  return m_ctl;
      4'd4:  return m_mask;
      4'd5:  return m_raw;
      4'd6:  return m_raw & m_mask;
      4'd8:  return {sp ? 16'h0 : m_lhi, m_llo};
      4'd9:  return {16'h0, m_lhi};
      4'd10: return {sp ? 16'h0 : m_mhi, m_mlo};
      4'd11: return {16'h0, m_mhi};
      4'd12: return m_secs;
      4'd13: return m_pa;
      4'd14: return m_pb;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_ma = 0; m_mb = 0; m_ctl = 0; m_mask = 0; m_raw = 0;
      m_pa = 0; m_pb = 0; m_cnt = 0; m_secs = 0; m_trig = 0;
      m_llo = 0; m_lhi = 0; m_mlo = 0; m_mhi = 0;
    end else begin
      logic t_out, w_evt, go, sp, down_on;
      logic [31:0] rl, mt;
      rl = {m_lhi, m_llo};
      mt = {m_mhi, m_mlo};
      sp = m_cfg >= 4;
      down_on = m_ctl[0] && m_cfg == 0;
      t_out = down_on && m_cnt == 0;
      w_evt = tick && m_ctl[0] && m_cfg == 1 && m_secs >= mt;
      go = wen && addr == 4'd3 && wdata[0] && !m_ctl[0];
      if (go) m_cnt = rl;
      else if (down_on) m_cnt = (m_cnt == 0) ? rl : m_cnt - 1;
      if (tick && m_ctl[0] && m_cfg == 1) m_secs = w_evt ? 0 : m_secs + 1;
      m_trig = t_out && m_ctl[5];
      if (wen && addr == 4'd7) m_raw = m_raw & ~wdata;
      if (t_out) m_raw[0] = 1'b1;
      if (w_evt) m_raw[3] = 1'b1;
      if (wen && addr == 4'd3) m_ctl = wdata;
      else if (t_out && m_ma[0]) m_ctl[0] = 1'b0;
      if (wen) begin
        case (addr)
          4'd0:  m_cfg = wdata;
          4'd1:  m_ma = wdata;
          4'd2:  m_mb = wdata;
          4'd4:  m_mask = wdata & 32'h77;
          4'd8:  begin m_llo = wdata[15:0]; if (!sp) m_lhi = wdata[31:16]; end
          4'd9:  m_lhi = wdata[15:0];
          4'd10: begin m_mlo = wdata[15:0]; if (!sp) m_mhi = wdata[31:16]; end
          4'd11: m_mhi = wdata[15:0];
          4'd13: m_pa = wdata;
          4'd14: m_pb = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of the level outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 irq", {31'h0, irq}, {31'h0, |(m_raw & m_mask)});
      chk("R6 trig", {31'h0, trig}, {31'h0, m_trig});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wen = 1'b1;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic rd_x(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
    chk({tag, " model"}, rdata, m_read(a));
  endtask

  task automatic rd_m(input logic [3:0] a, input string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, m_read(a));
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 16; i++) rd_x(4'(i), 32'h0, "R1");
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 trig", {31'h0, trig}, 32'h0);
    // R10 unused address
    wr(4'd15, 32'hFFFF_FFFF);
    for (int i = 0; i < 15; i++) rd_x(4'(i), 32'h0, "R10");
    rd_x(4'd15, 32'h0, "R10");
    // R8 mask width
    wr(4'd4, 32'hFFFF_FFFF);
    rd_x(4'd4, 32'h77, "R8");
    // R2 split and combined halves
    wr(4'd0, 32'd4);
    wr(4'd8, 32'hAAAA_5555);
    rd_x(4'd8, 32'h0000_5555, "R2");
    wr(4'd9, 32'h1234);
    rd_x(4'd9, 32'h1234, "R2");
    wr(4'd0, 32'd0);
    rd_x(4'd8, 32'h1234_5555, "R2");
    wr(4'd10, 32'hBEEF_0001);
    rd_x(4'd10, 32'hBEEF_0001, "R2");
    rd_x(4'd11, 32'h0000_BEEF, "R2");
    wr(4'd8, 32'd5);
    rd_x(4'd8, 32'd5, "R2");
    // R3 first timeout, periodic with trigger
    wr(4'd3, 32'h21);
    repeat (4) @(negedge clk);
    rd_x(4'd5, 32'h0, "R3");
    rd_x(4'd5, 32'h1, "R3");
    chk("R6 pulse", {31'h0, trig}, 32'h1);
    // R9 clear landing on the timeout edge
    repeat (4) @(negedge clk);
    wr(4'd7, 32'h1);
    rd_x(4'd5, 32'h1, "R9");
    rd_x(4'd7, 32'h0, "R9");
    wr(4'd7, 32'h1);
    rd_x(4'd5, 32'h0, "R9");
    rd_x(4'd5, 32'h1, "R4");
    // R11 stop
    wr(4'd3, 32'h0);
    wr(4'd7, 32'h1);
    repeat (20) @(negedge clk);
    rd_x(4'd5, 32'h0, "R11");
    rd_m(4'd6, "R8");
    // R5 one-shot
    wr(4'd1, 32'h1);
    wr(4'd8, 32'd3);
    wr(4'd3, 32'h1);
    repeat (8) @(negedge clk);
    rd_x(4'd3, 32'h0, "R5");
    rd_x(4'd5, 32'h1, "R5");
    wr(4'd7, 32'h1);
    repeat (10) @(negedge clk);
    rd_x(4'd5, 32'h0, "R5");
    // R5 control write on the one-shot timeout edge
    wr(4'd3, 32'h1);
    repeat (2) @(negedge clk);
    wr(4'd3, 32'h21);
    rd_x(4'd3, 32'h21, "R5");
    repeat (6) @(negedge clk);
    rd_m(4'd3, "R5");
    wr(4'd3, 32'h0);
    // R7 seconds mode
    wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd0, 32'd1);
    wr(4'd10, 32'd2);
    wr(4'd3, 32'h1);
    rd_x(4'd12, 32'd0, "R7");
    pulse_tick();
    rd_x(4'd12, 32'd1, "R7");
    pulse_tick();
    rd_x(4'd12, 32'd2, "R7");
    pulse_tick();
    rd_x(4'd12, 32'd0, "R7");
    rd_x(4'd5, 32'h8, "R7");
    rd_x(4'd6, 32'h0, "R8");
    chk("R8 irq low", {31'h0, irq}, 32'h0);
    pulse_tick();
    wr(4'd3, 32'h0);
    pulse_tick();
    rd_x(4'd12, 32'd1, "R7");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected 0", 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule